// File: doc/BRIEF.md
# Two-Level Nested Interrupt Priority Controller

This block arbitrates five interrupt request flags for a small microcontroller core: two external inputs, two timer overflows and a serial port. A small register port holds a global enable, a per-source enable mask and a per-source priority bit. From these settings and the pending flags, the block computes a request to the CPU and the index of the source that would be serviced.

The block keeps two in-service flip-flops, one for each service level. When the CPU enters a handler, it pulses an acknowledge. The block then marks the winner's level as in service, latches the winner's index and pulses a one-hot clear strobe back to the winning source's flag. When the handler exits, the CPU pulses return-from-interrupt, which restores the previous masking level.

A running low-level handler can be preempted by a high-level request. Nothing preempts a running high-level handler.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After synchronous reset, the global enable, the five enable bits, the five priority bits and both in-service flags read back as zero, and `irq_req` is low even with all sources pending.
- R2: Register port, read combinationally at `cfg_addr`:
  - Address 0: bit 0 is the global enable.
  - Address 1: bits 4:0 are the enable mask.
  - Address 2: bits 4:0 are the priority mask, where 1 means high.
  - Address 3: reads {high in-service, low in-service} in bits 1:0, and writes to it have no effect.
  - Unused bits read 0.
  - Bit i maps to source index i: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4.
- R3: While the global enable is 0, `irq_req` stays low whatever the pending and enable bits are.
- R4: A pending source whose enable bit is 0 never causes `irq_req` and is never chosen as the winner.
- R5: Among eligible requests of the same level, the winner is the lowest index, which gives the order external 0, timer 0, external 1, timer 1, serial.
- R6: Any eligible high-priority request wins over every eligible low-priority request.
- R7: While the high in-service flag is set, `irq_req` is low. While only the low flag is set, `irq_req` rises only for a high-priority request.
- R8: An `irq_ack` seen while `irq_req` is high has three effects on the next cycle:
  - It sets the in-service flag of the winner's level.
  - It loads `svc_idx` with the winner's index.
  - It drives `clr_pulse` one-hot on the winner's bit for exactly one cycle.
- R9: An `irq_ack` seen while `irq_req` is low changes no in-service flag, leaves `svc_idx` unchanged and produces no clear pulse.
- R10: An `irq_ret` pulse clears the high in-service flag if it is set, and otherwise clears the low flag.
- R11: `irq_req` and `irq_idx` follow changes of `src_pend` and of the configuration combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data at `cfg_addr` |
| src_pend | input | 5 | Pending request flags, bit i = source i |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_idx | output | 3 | Index of the current winner |
| irq_ack | input | 1 | Handler entry pulse |
| irq_ret | input | 1 | Handler exit pulse |
| svc_idx | output | 3 | Index latched on the last accepted acknowledge |
| clr_pulse | output | 5 | One-cycle clear strobe to the serviced source's flag |

## Verification
The winner logic is tried with the following input patterns:
- **Shrinking pending sets at one level.** Each step removes the current winner, so every position in the fixed order is reached. This separates lowest-index polling from any other tie rule.
- **Mixed-priority patterns.** The high source is placed at a late index. This separates "high beats low" from plain index order.
- **Patterns with an enable bit or the global enable cleared.** These show that masking is applied before arbitration rather than after.
- **Nested acknowledge and return sequences.** These separate the two masking levels and check that each return clears the flag for the correct level.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int NSRC   = 5;
    localparam int IDX_W  = 3;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        CFG_GLOBAL = 2'd0,
        CFG_ENABLE = 2'd1,
        CFG_PRIO   = 2'd2,
        CFG_STATUS = 2'd3
    } cfg_addr_e;

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4
    } src_e;

    typedef struct packed {
        logic            gie;
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] prio;
    } cfg_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic logic [NSRC-1:0] idx_to_onehot(input logic [IDX_W-1:0] idx);
        logic [NSRC-1:0] oh;
        oh = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (idx == IDX_W'(i)) oh[i] = 1'b1;
        end
        return oh;
    endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import irq_nest_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int IW = IDX_W
) (
    input  logic [N-1:0]  vec,
    output logic          valid,
    output logic [IW-1:0] idx
);
    logic [N:0]   seen;
    logic [N-1:0] grant;

    assign seen[0] = 1'b0;

    generate
        for (genvar g = 0; g < N; g++) begin : g_chain
            assign seen[g+1] = seen[g] | vec[g];
            assign grant[g]  = vec[g] & ~seen[g];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (grant[i]) idx = idx | IW'(i);
        end
    end

    assign valid = seen[N];

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_nest_pkg::*;
#(
    parameter int N  = NSRC,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    status,
    output logic          gie,
    output logic [N-1:0]  en,
    output logic [N-1:0]  prio,
    output logic [DW-1:0] rdata
);
    logic          gie_q;
    logic [N-1:0]  en_q;
    logic [N-1:0]  prio_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q  <= 1'b0;
            en_q   <= '0;
            prio_q <= '0;
        end else if (we) begin
            case (cfg_addr_e'(addr))
                CFG_GLOBAL: gie_q  <= wdata[0];
                CFG_ENABLE: en_q   <= wdata[N-1:0];
                CFG_PRIO:   prio_q <= wdata[N-1:0];
                default:    ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (cfg_addr_e'(addr))
            CFG_GLOBAL: rdata[0]     = gie_q;
            CFG_ENABLE: rdata[N-1:0] = en_q;
            CFG_PRIO:   rdata[N-1:0] = prio_q;
            default:    rdata[1:0]   = status;
        endcase
    end

    assign gie  = gie_q;
    assign en   = en_q;
    assign prio = prio_q;

    // R1: configuration is cleared one cycle after reset
    a_r1_cfg_reset: assert property (@(posedge clk)
        rst |=> (!gie_q && en_q == '0 && prio_q == '0));

    // R2: a write to the status address leaves configuration untouched
    a_r2_status_ro: assert property (@(posedge clk) disable iff (rst)
        (we && cfg_addr_e'(addr) == CFG_STATUS) |=> ($stable(gie_q) && $stable(en_q) && $stable(prio_q)));

endmodule

// File: rtl/irq_level_track.sv
module irq_level_track (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic take_hi,
    input  logic ret,
    output logic in_hi,
    output logic in_lo
);
    logic hi_q, lo_q;
    logic hi_d, lo_d;

    always_comb begin
        hi_d = hi_q;
        lo_d = lo_q;
        if (ret) begin
            if (hi_q) hi_d = 1'b0;
            else      lo_d = 1'b0;
        end
        if (take) begin
            if (take_hi) hi_d = 1'b1;
            else         lo_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    assign in_hi = hi_q;
    assign in_lo = lo_q;

    // R10: return clears the high level first
    a_r10_ret_hi: assert property (@(posedge clk) disable iff (rst)
        (ret && hi_q && !take) |=> (!hi_q && $stable(lo_q)));

    // R10: with no high handler, return clears the low level
    a_r10_ret_lo: assert property (@(posedge clk) disable iff (rst)
        (ret && !hi_q && !take) |=> (!lo_q && !hi_q));

    // R8: an accepted high-level entry marks the high level in service
    a_r8_take_hi: assert property (@(posedge clk) disable iff (rst)
        (take && take_hi) |=> hi_q);

    // R8: an accepted low-level entry marks the low level in service
    a_r8_take_lo: assert property (@(posedge clk) disable iff (rst)
        (take && !take_hi) |=> lo_q);

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
#(
    parameter int N_SRC = NSRC,
    parameter int IW    = IDX_W,
    parameter int DW    = DATA_W,
    parameter int AW    = ADDR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_wdata,
    output logic [DW-1:0]    cfg_rdata,
    input  logic [N_SRC-1:0] src_pend,
    output logic             irq_req,
    output logic [IW-1:0]    irq_idx,
    input  logic             irq_ack,
    input  logic             irq_ret,
    output logic [IW-1:0]    svc_idx,
    output logic [N_SRC-1:0] clr_pulse
);
    logic             gie;
    logic [N_SRC-1:0] en, prio;
    logic             in_hi, in_lo;
    logic [N_SRC-1:0] eligible, hi_set, lo_set;
    logic             hi_valid, lo_valid;
    logic [IW-1:0]    hi_idx, lo_idx;
    logic             win_hi;
    logic             take;
    logic [IW-1:0]    svc_q;
    logic [N_SRC-1:0] clr_q;

    irq_cfg_regs #(.N(N_SRC), .DW(DW), .AW(AW)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .status ({in_hi, in_lo}),
        .gie    (gie),
        .en     (en),
        .prio   (prio),
        .rdata  (cfg_rdata)
    );

    assign eligible = src_pend & en & {N_SRC{gie}};
    assign hi_set   = eligible & prio;
    assign lo_set   = eligible & ~prio;

    irq_pick #(.N(N_SRC), .IW(IW)) u_pick_hi (
        .vec   (hi_set),
        .valid (hi_valid),
        .idx   (hi_idx)
    );

    irq_pick #(.N(N_SRC), .IW(IW)) u_pick_lo (
        .vec   (lo_set),
        .valid (lo_valid),
        .idx   (lo_idx)
    );

    always_comb begin
        win_hi  = hi_valid;
        irq_idx = hi_valid ? hi_idx : lo_idx;
        if (in_hi)         irq_req = 1'b0;
        else if (hi_valid) irq_req = 1'b1;
        else if (in_lo)    irq_req = 1'b0;
        else               irq_req = lo_valid;
    end

    assign take = irq_ack & irq_req;

    irq_level_track u_level (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .take_hi (win_hi),
        .ret     (irq_ret),
        .in_hi   (in_hi),
        .in_lo   (in_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_q <= '0;
            clr_q <= '0;
        end else begin
            clr_q <= '0;
            if (take) begin
                svc_q <= irq_idx;
                clr_q <= idx_to_onehot(irq_idx);
            end
        end
    end

    assign svc_idx   = svc_q;
    assign clr_pulse = clr_q;

    // R7: a running high-level handler masks every request
    a_r7_hi_masks_all: assert property (@(posedge clk) disable iff (rst)
        in_hi |-> !irq_req);

    // R3: global enable off keeps the request low
    a_r3_gie_blocks: assert property (@(posedge clk) disable iff (rst)
        !gie |-> !irq_req);

    // R4: the reported winner is always pending and enabled
    a_r4_winner_eligible: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ((eligible & idx_to_onehot(irq_idx)) != '0));

    // R8: clear strobe has at most one bit and lasts one cycle
    a_r8_clr_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr_pulse));

    a_r8_clr_single: assert property (@(posedge clk) disable iff (rst)
        (clr_pulse != '0) |=> (clr_pulse == '0 || $past(take)));

    // R9: an acknowledge without a request leaves no strobe
    a_r9_ack_ignored: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !irq_req) |=> (clr_pulse == '0 && $stable(svc_idx)));

endmodule

// File: tb/tb_irq_nest_ctrl.sv
module tb_irq_nest_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [1:0] cfg_addr;
    logic [7:0] cfg_wdata;
    logic [7:0] cfg_rdata;
    logic [4:0] src_pend;
    logic       irq_req;
    logic [2:0] irq_idx;
    logic       irq_ack;
    logic       irq_ret;
    logic [2:0] svc_idx;
    logic [4:0] clr_pulse;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_nest_ctrl dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .src_pend(src_pend),
        .irq_req(irq_req), .irq_idx(irq_idx), .irq_ack(irq_ack),
        .irq_ret(irq_ret), .svc_idx(svc_idx), .clr_pulse(clr_pulse)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic pend(input logic [4:0] p);
        src_pend = p;
        #1;
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic pulse_ret();
        @(negedge clk);
        irq_ret = 1'b1;
        @(negedge clk);
        irq_ret = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        pend(5'h1F);
        rd(2'd0, v); chk("R1 gie", v, 8'h00);
        rd(2'd1, v); chk("R1 enable", v, 8'h00);
        rd(2'd2, v); chk("R1 prio", v, 8'h00);
        rd(2'd3, v); chk("R1 status", v, 8'h00);
        chk("R1 irq_req", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(2'd1, 8'hFF); rd(2'd1, v); chk("R2 enable readback", v, 8'h1F);
        wr(2'd2, 8'h0A); rd(2'd2, v); chk("R2 prio readback", v, 8'h0A);
        wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 gie readback", v, 8'h01);
        wr(2'd3, 8'hFF); rd(2'd3, v); chk("R2 status write ignored", v, 8'h00);
        rd(2'd1, v); chk("R2 enable after status write", v, 8'h1F);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_global();
        wr(2'd1, 8'h1F); wr(2'd0, 8'h00);
        pend(5'h1F);
        chk("R3 gie off blocks", {7'd0, irq_req}, 8'h00);
        wr(2'd0, 8'h01); pend(5'h1F);
        chk("R3 gie on raises", {7'd0, irq_req}, 8'h01);
    endtask

    task automatic t_enable();
        wr(2'd1, 8'h1E);
        pend(5'h01);
        chk("R4 disabled source", {7'd0, irq_req}, 8'h00);
        pend(5'h03);
        chk("R4 disabled skipped idx", {5'd0, irq_idx}, 8'd1);
        wr(2'd1, 8'h1F);
    endtask

    task automatic t_order();
        logic [4:0] p = 5'h1F;
        for (int i = 0; i < 5; i++) begin
            pend(p);
            chk("R5 fixed order idx", {5'd0, irq_idx}, 8'(i));
            chk("R11 req follows pend", {7'd0, irq_req}, 8'h01);
            p[i] = 1'b0;
        end
        pend(5'h00);
        chk("R11 req drops", {7'd0, irq_req}, 8'h00);
    endtask

    task automatic t_hi_beats();
        wr(2'd2, 8'h10); pend(5'h1F);
        chk("R6 serial high wins", {5'd0, irq_idx}, 8'd4);
        wr(2'd2, 8'h18); pend(5'h1F);
        chk("R6 two high lowest idx", {5'd0, irq_idx}, 8'd3);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_nest();
        logic [7:0] v;
        pend(5'h0C);
        chk("R5 ext1 wins", {5'd0, irq_idx}, 8'd2);
        pulse_ack();
        chk("R8 clr pulse", {3'd0, clr_pulse}, 8'h04);
        chk("R8 svc idx", {5'd0, svc_idx}, 8'd2);
        rd(2'd3, v); chk("R8 low in service", v, 8'h01);
        @(negedge clk); #1;
        chk("R8 clr one cycle", {3'd0, clr_pulse}, 8'h00);
        chk("R7 low masks low", {7'd0, irq_req}, 8'h00);
        wr(2'd2, 8'h08); pend(5'h0C);
        chk("R7 high preempts low", {7'd0, irq_req}, 8'h01);
        chk("R7 preempt idx", {5'd0, irq_idx}, 8'd3);
        pulse_ack();
        chk("R8 clr pulse high", {3'd0, clr_pulse}, 8'h08);
        rd(2'd3, v); chk("R8 both in service", v, 8'h03);
        #1;
        chk("R7 high masks all", {7'd0, irq_req}, 8'h00);
        pulse_ret();
        rd(2'd3, v); chk("R10 ret clears high", v, 8'h01);
        pulse_ret();
        rd(2'd3, v); chk("R10 ret clears low", v, 8'h00);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_ack_ignored();
        logic [7:0] v;
        wr(2'd0, 8'h00); pend(5'h1F);
        pulse_ack();
        chk("R9 no clr pulse", {3'd0, clr_pulse}, 8'h00);
        chk("R9 svc idx held", {5'd0, svc_idx}, 8'd3);
        rd(2'd3, v); chk("R9 status unchanged", v, 8'h00);
    endtask

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        src_pend = '0; irq_ack = 1'b0; irq_ret = 1'b0;
        t_reset();
        t_regs();
        t_global();
        t_enable();
        t_order();
        t_hi_beats();
        t_nest();
        t_ack_ignored();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule